// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor and decides which single interrupt is offered to it. It keeps one pending slot (a source number and that source's priority), the processor's priority threshold, and the priority of a software inter-processor interrupt (IPI). Lower priority values are more favoured. Source controllers offer requests. The presenter answers each request with a taken pulse or a refused pulse. When a more favoured request or an IPI replaces a pending external interrupt, the presenter sends a reject back to the displaced source so that the source can offer it again later.

The processor drives register-style operations. Accept reads and claims the pending interrupt. End-of-interrupt restores the threshold and tells the sources that handling is finished. The processor can also set the threshold, set the IPI priority, or poll without side effects. When the slot is empty and the threshold allows more, the presenter first checks the IPI and then pulses a resend request to the sources. Every operation resolves in one clock, and every answer or pulse appears on the cycle after the strobe.

Top module: `irq_presenter`

## Requirements
- R1: After reset, the presentation word (threshold and source number) is zero, both the pending priority and the IPI priority are 0xFF, and the interrupt line is low. An accept issued straight after reset returns 0x00000000 and leaves the threshold at 0xFF.
- R2: The presentation word returned by accept and poll carries the threshold in bits 31:24 and the pending source number in bits 23:0. A source number of zero means the slot is empty, and the interrupt line is high exactly when the slot holds a nonzero number.
- R3: A request is refused with a `src_refused` pulse, and leaves all state unchanged, if its priority is greater than or equal to the threshold, or if the slot is occupied by a priority less than or equal to the request's.
- R4: A winning request raises `src_taken`. It latches its number and priority and drives the interrupt line high. If it displaced an external source, a reject carrying that source's number is sent.
- R5: Accept (opcode 1) returns the presentation word, lowers the line, copies the pending priority into the threshold, empties the slot and sets the pending priority to 0xFF.
- R6: Set-threshold (opcode 3, value in bits 7:0) with a value below the old threshold drops the pending interrupt when the new value is less than or equal to the pending priority. A drop empties the slot, lowers the line and rejects the source. A pending interrupt with a priority better than the new threshold is kept.
- R7: Set-threshold with a value equal to or above the old one, while the slot is empty, pulses `resend_req`. Before that it presents the IPI if the IPI priority is below the new threshold.
- R8: Set-IPI (opcode 4, value in bits 7:0) stores the IPI priority. If that priority is below the threshold and no pending priority is less than or equal to it, the IPI is presented as source number 2 with the IPI priority, and the line is raised.
- R9: End-of-interrupt (opcode 2) loads the threshold from bits 31:24 of the operand and pulses `eoi_valid` with bits 23:0. If the slot is empty, it then runs the IPI check and the resend request against the new threshold.
- R10: An IPI that is displaced or dropped produces no reject. Rejects only ever carry external source numbers.
- R11: A source request arriving in the same cycle as a processor operation is refused and does not change the slot.
- R12: Poll (opcode 5) returns the presentation word and the IPI priority on `rsp_ipi` without changing state. Opcodes 0, 6 and 7 have no effect.
- R13: `src_taken`, `src_refused`, `rej_valid`, `eoi_valid`, `resend_req` and `rsp_valid` are single-cycle pulses on the cycle after the strobe. They drop on the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Request strobe from a source controller |
| src_num | input | 24 | Requesting source number |
| src_prio | input | 8 | Requesting source priority |
| src_taken | output | 1 | Request was latched into the slot |
| src_refused | output | 1 | Request was turned away |
| op_valid | input | 1 | Processor operation strobe |
| op_code | input | 3 | Operation: 1 accept, 2 EOI, 3 set threshold, 4 set IPI, 5 poll |
| op_data | input | 32 | Operation operand |
| rsp_valid | output | 1 | Response to accept or poll |
| rsp_data | output | 32 | Presentation word |
| rsp_ipi | output | 8 | IPI priority (poll) |
| rej_valid | output | 1 | Reject pulse to the sources |
| rej_num | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the sources |
| eoi_num | output | 24 | Source number being ended |
| resend_req | output | 1 | Ask the sources to offer rejected work again |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The request path is tried with a priority at the threshold, one equal to the pending priority, and one strictly better. These cases separate the greater-or-equal refusals from the strict-win case, and separate a displacement that sends a reject from one that replaces an IPI and sends none. Threshold writes are tried lower-with-drop, lower-without-drop, equal-or-higher while empty, and higher with the IPI both below and above the new value. These show whether the drop and resend branches and the IPI check use the new threshold. End-of-interrupt is tried with an empty slot and with an occupied one, which shows whether the resend is conditional. A request that coincides with an operation, an idle cycle after a pulse, an unknown opcode and a mid-run reset close the set.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONE    = 3'd0,
    OP_ACCEPT  = 3'd1,
    OP_EOI     = 3'd2,
    OP_SET_THR = 3'd3,
    OP_SET_IPI = 3'd4,
    OP_POLL    = 3'd5
  } op_e;

endpackage

// File: rtl/req_judge.sv
module req_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] req_prio,
  input  logic [PRIO_W-1:0] thr,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              busy,
  output logic              win
);

  // A request wins only if strictly better than the threshold and
  // strictly better than whatever already sits in the slot.
  function automatic logic beats(input logic [PRIO_W-1:0] p,
                                 input logic [PRIO_W-1:0] t,
                                 input logic [PRIO_W-1:0] held,
                                 input logic              occ);
    return (p < t) && (!occ || (p < held));
  endfunction

  assign win = beats(req_prio, thr, pend_prio, busy);

endmodule

// File: rtl/ipi_judge.sv
module ipi_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [PRIO_W-1:0] thr,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              busy,
  output logic              present
);

  // The IPI goes in when it is below the threshold and nothing held
  // is at least as favoured.
  function automatic logic ipi_goes(input logic [PRIO_W-1:0] ip,
                                    input logic [PRIO_W-1:0] t,
                                    input logic [PRIO_W-1:0] held,
                                    input logic              occ);
    return (ip < t) && !(occ && (held <= ip));
  endfunction

  assign present = ipi_goes(ipi_prio, thr, pend_prio, busy);

endmodule

// File: rtl/thr_judge.sv
module thr_judge #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] new_thr,
  input  logic [PRIO_W-1:0] old_thr,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              busy,
  output logic              drop,
  output logic              want_resend
);

  function automatic logic tightens(input logic [PRIO_W-1:0] n,
                                    input logic [PRIO_W-1:0] o);
    return n < o;
  endfunction

  // Tightening below a held priority evicts it; relaxing with an empty
  // slot invites the sources to try again.
  assign drop        = tightens(new_thr, old_thr) && busy && (new_thr <= pend_prio);
  assign want_resend = !tightens(new_thr, old_thr) && !busy;

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int NUM_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_NUM = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     src_valid,
  input  logic [NUM_W-1:0]         src_num,
  input  logic [PRIO_W-1:0]        src_prio,
  output logic                     src_taken,
  output logic                     src_refused,
  input  logic                     op_valid,
  input  logic [OP_W-1:0]          op_code,
  input  logic [NUM_W+PRIO_W-1:0]  op_data,
  output logic                     rsp_valid,
  output logic [NUM_W+PRIO_W-1:0]  rsp_data,
  output logic [PRIO_W-1:0]        rsp_ipi,
  output logic                     rej_valid,
  output logic [NUM_W-1:0]         rej_num,
  output logic                     eoi_valid,
  output logic [NUM_W-1:0]         eoi_num,
  output logic                     resend_req,
  output logic                     irq_out
);

  localparam int              REG_W     = NUM_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};
  localparam logic [NUM_W-1:0]  IPI_SRC   = NUM_W'(IPI_NUM);

  // architectural state
  logic [PRIO_W-1:0] thr_q, thr_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [PRIO_W-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] ipi_q, ipi_d;
  logic              from_ipi_q, from_ipi_d;
  logic              irq_d;

  // registered answers
  logic              taken_d, refused_d, rsp_v_d, rej_v_d, eoi_v_d, resend_d;
  logic [REG_W-1:0]  rsp_d;
  logic [PRIO_W-1:0] rsp_ipi_d;
  logic [NUM_W-1:0]  rej_n_d, eoi_n_d;

  // named internal events
  logic              busy;
  logic              req_win;
  logic              ipi_present;
  logic              thr_drop;
  logic              thr_resend;
  logic              run_resend;
  logic              run_ipi;
  logic [PRIO_W-1:0] op_lo;
  logic [PRIO_W-1:0] op_hi;
  logic [PRIO_W-1:0] ipi_cand;
  logic [PRIO_W-1:0] thr_cand;

  assign busy  = (num_q != '0);
  assign op_lo = op_data[PRIO_W-1:0];
  assign op_hi = op_data[REG_W-1:NUM_W];

  // candidate values seen by the IPI check depend on the operation
  always_comb begin
    ipi_cand = ipi_q;
    thr_cand = thr_q;
    if (op_valid && (op_code == OP_SET_IPI)) ipi_cand = op_lo;
    if (op_valid && (op_code == OP_SET_THR)) thr_cand = op_lo;
    if (op_valid && (op_code == OP_EOI))     thr_cand = op_hi;
  end

  req_judge #(.PRIO_W(PRIO_W)) u_req (
    .req_prio (src_prio),
    .thr      (thr_q),
    .pend_prio(pend_q),
    .busy     (busy),
    .win      (req_win)
  );

  ipi_judge #(.PRIO_W(PRIO_W)) u_ipi (
    .ipi_prio (ipi_cand),
    .thr      (thr_cand),
    .pend_prio(pend_q),
    .busy     (busy),
    .present  (ipi_present)
  );

  thr_judge #(.PRIO_W(PRIO_W)) u_thr (
    .new_thr    (op_lo),
    .old_thr    (thr_q),
    .pend_prio  (pend_q),
    .busy       (busy),
    .drop       (thr_drop),
    .want_resend(thr_resend)
  );

  always_comb begin
    thr_d      = thr_q;
    num_d      = num_q;
    pend_d     = pend_q;
    ipi_d      = ipi_q;
    from_ipi_d = from_ipi_q;
    irq_d      = irq_out;
    taken_d    = 1'b0;
    refused_d  = 1'b0;
    rsp_v_d    = 1'b0;
    rsp_d      = '0;
    rsp_ipi_d  = '0;
    rej_v_d    = 1'b0;
    rej_n_d    = '0;
    eoi_v_d    = 1'b0;
    eoi_n_d    = '0;
    resend_d   = 1'b0;
    run_resend = 1'b0;
    run_ipi    = 1'b0;

    if (op_valid) begin
      refused_d = src_valid;
      case (op_code)
        OP_ACCEPT: begin
          rsp_v_d    = 1'b1;
          rsp_d      = {thr_q, num_q};
          thr_d      = pend_q;
          num_d      = '0;
          pend_d     = PRIO_IDLE;
          from_ipi_d = 1'b0;
          irq_d      = 1'b0;
        end
        OP_POLL: begin
          rsp_v_d   = 1'b1;
          rsp_d     = {thr_q, num_q};
          rsp_ipi_d = ipi_q;
        end
        OP_SET_THR: begin
          thr_d = op_lo;
          if (thr_drop) begin
            num_d      = '0;
            pend_d     = PRIO_IDLE;
            from_ipi_d = 1'b0;
            irq_d      = 1'b0;
            if (!from_ipi_q) begin
              rej_v_d = 1'b1;
              rej_n_d = num_q;
            end
          end else if (thr_resend) begin
            run_resend = 1'b1;
          end
        end
        OP_SET_IPI: begin
          ipi_d   = op_lo;
          run_ipi = 1'b1;
        end
        OP_EOI: begin
          thr_d   = op_hi;
          eoi_v_d = 1'b1;
          eoi_n_d = op_data[NUM_W-1:0];
          if (!busy) run_resend = 1'b1;
        end
        default: ;
      endcase

      if ((run_resend || run_ipi) && ipi_present) begin
        if (busy && !from_ipi_q) begin
          rej_v_d = 1'b1;
          rej_n_d = num_q;
        end
        num_d      = IPI_SRC;
        pend_d     = ipi_cand;
        from_ipi_d = 1'b1;
        irq_d      = 1'b1;
      end
      resend_d = run_resend;
    end else if (src_valid) begin
      if (req_win) begin
        if (busy && !from_ipi_q) begin
          rej_v_d = 1'b1;
          rej_n_d = num_q;
        end
        num_d      = src_num;
        pend_d     = src_prio;
        from_ipi_d = 1'b0;
        irq_d      = 1'b1;
        taken_d    = 1'b1;
      end else begin
        refused_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q       <= '0;
      num_q       <= '0;
      pend_q      <= PRIO_IDLE;
      ipi_q       <= PRIO_IDLE;
      from_ipi_q  <= 1'b0;
      irq_out     <= 1'b0;
      src_taken   <= 1'b0;
      src_refused <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_ipi     <= '0;
      rej_valid   <= 1'b0;
      rej_num     <= '0;
      eoi_valid   <= 1'b0;
      eoi_num     <= '0;
      resend_req  <= 1'b0;
    end else begin
      thr_q       <= thr_d;
      num_q       <= num_d;
      pend_q      <= pend_d;
      ipi_q       <= ipi_d;
      from_ipi_q  <= from_ipi_d;
      irq_out     <= irq_d;
      src_taken   <= taken_d;
      src_refused <= refused_d;
      rsp_valid   <= rsp_v_d;
      rsp_data    <= rsp_d;
      rsp_ipi     <= rsp_ipi_d;
      rej_valid   <= rej_v_d;
      rej_num     <= rej_n_d;
      eoi_valid   <= eoi_v_d;
      eoi_num     <= eoi_n_d;
      resend_req  <= resend_d;
    end
  end

  // R3 R4
  answer_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> (src_taken != src_refused));

  // R4
  taken_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_taken |-> irq_out);

  // R5
  accept_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_ACCEPT)) |=> (!irq_out && rsp_valid));

  // R10
  rej_not_ipi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_num != IPI_SRC));

  // R11
  concurrent_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && src_valid) |=> (src_refused && !src_taken));

  // R2
  line_matches_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == busy);

endmodule

// File: tb/irq_presenter_bench.sv
module irq_presenter_bench;

  localparam logic [2:0] C_ACC  = 3'd1;
  localparam logic [2:0] C_EOI  = 3'd2;
  localparam logic [2:0] C_THR  = 3'd3;
  localparam logic [2:0] C_IPI  = 3'd4;
  localparam logic [2:0] C_POLL = 3'd5;

  // expected flag order: irq, taken, refused, rej, eoi, resend, rsp
  typedef struct packed {
    logic        is_src;
    logic [2:0]  code;
    logic [31:0] data;
    logic [7:0]  prio;
    logic [6:0]  flg;
    logic [23:0] num;
    logic [31:0] rsp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, C_POLL, 32'h0,        8'h00, 7'b0000001, 24'h0,  32'h0,        8'd1 },  // R1
    '{1'b1, 3'd0,   32'h10,       8'h05, 7'b0010000, 24'h0,  32'h0,        8'd3 },  // R3
    '{1'b0, C_THR,  32'h80,       8'h00, 7'b0000010, 24'h0,  32'h0,        8'd7 },  // R7
    '{1'b1, 3'd0,   32'h10,       8'h40, 7'b1100000, 24'h0,  32'h0,        8'd4 },  // R4
    '{1'b1, 3'd0,   32'h11,       8'h40, 7'b1010000, 24'h0,  32'h0,        8'd3 },  // R3
    '{1'b1, 3'd0,   32'h12,       8'h20, 7'b1101000, 24'h10, 32'h0,        8'd4 },  // R4
    '{1'b0, C_POLL, 32'h0,        8'h00, 7'b1000001, 24'h0,  32'h80000012, 8'd2 },  // R2
    '{1'b0, C_IPI,  32'h30,       8'h00, 7'b1000000, 24'h0,  32'h0,        8'd8 },  // R8
    '{1'b0, C_IPI,  32'h10,       8'h00, 7'b1001000, 24'h12, 32'h0,        8'd8 },  // R8
    '{1'b1, 3'd0,   32'h13,       8'h08, 7'b1100000, 24'h0,  32'h0,        8'd10},  // R10
    '{1'b0, C_ACC,  32'h0,        8'h00, 7'b0000001, 24'h0,  32'h80000013, 8'd5 },  // R5
    '{1'b0, C_POLL, 32'h0,        8'h00, 7'b0000001, 24'h0,  32'h08000000, 8'd5 },  // R5
    '{1'b0, C_EOI,  32'h80000013, 8'h00, 7'b1000110, 24'h13, 32'h0,        8'd9 },  // R9
    '{1'b0, C_POLL, 32'h0,        8'h00, 7'b1000001, 24'h0,  32'h80000002, 8'd8 },  // R8
    '{1'b0, C_THR,  32'h10,       8'h00, 7'b0000000, 24'h0,  32'h0,        8'd10},  // R10
    '{1'b0, C_THR,  32'h60,       8'h00, 7'b1000010, 24'h0,  32'h0,        8'd7 },  // R7
    '{1'b0, C_ACC,  32'h0,        8'h00, 7'b0000001, 24'h0,  32'h60000002, 8'd5 },  // R5
    '{1'b0, C_IPI,  32'hFF,       8'h00, 7'b0000000, 24'h0,  32'h0,        8'd8 },  // R8
    '{1'b0, C_THR,  32'h90,       8'h00, 7'b0000010, 24'h0,  32'h0,        8'd7 },  // R7
    '{1'b1, 3'd0,   32'h21,       8'h50, 7'b1100000, 24'h0,  32'h0,        8'd4 },  // R4
    '{1'b0, C_THR,  32'h50,       8'h00, 7'b0001000, 24'h21, 32'h0,        8'd6 },  // R6
    '{1'b1, 3'd0,   32'h22,       8'h30, 7'b1100000, 24'h0,  32'h0,        8'd4 },  // R4
    '{1'b0, C_THR,  32'h20,       8'h00, 7'b0001000, 24'h22, 32'h0,        8'd6 },  // R6
    '{1'b0, C_THR,  32'h40,       8'h00, 7'b0000010, 24'h0,  32'h0,        8'd7 },  // R7
    '{1'b1, 3'd0,   32'h23,       8'h10, 7'b1100000, 24'h0,  32'h0,        8'd4 },  // R4
    '{1'b0, C_THR,  32'h30,       8'h00, 7'b1000000, 24'h0,  32'h0,        8'd6 },  // R6
    '{1'b0, C_POLL, 32'h0,        8'h00, 7'b1000001, 24'h0,  32'h30000023, 8'd2 },  // R2
    '{1'b0, C_EOI,  32'h40000023, 8'h00, 7'b1000100, 24'h23, 32'h0,        8'd9 },  // R9
    '{1'b0, 3'd7,   32'h0,        8'h00, 7'b1000000, 24'h0,  32'h0,        8'd12},  // R12
    '{1'b0, C_POLL, 32'h0,        8'h00, 7'b1000001, 24'h0,  32'h40000023, 8'd12}   // R12
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_valid = 1'b0;
  logic [23:0] src_num = '0;
  logic [7:0]  src_prio = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic        src_taken, src_refused, rsp_valid, rej_valid, eoi_valid, resend_req, irq_out;
  logic [31:0] rsp_data;
  logic [7:0]  rsp_ipi;
  logic [23:0] rej_num, eoi_num;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_presenter u_irq_presenter (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_num(src_num), .src_prio(src_prio),
    .src_taken(src_taken), .src_refused(src_refused),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ipi(rsp_ipi),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_req(resend_req), .irq_out(irq_out)
  );

  task automatic apply(input logic s, input logic [2:0] c, input logic [31:0] d,
                       input logic [7:0] p, input logic o);
    @(negedge clk);
    src_valid = s;
    src_num   = d[23:0];
    src_prio  = p;
    op_valid  = o;
    op_code   = c;
    op_data   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [6:0] flg,
                       input logic [23:0] num, input logic [31:0] rsp);
    logic [6:0]  of;
    logic [23:0] on;
    logic [31:0] orsp;
    of   = {irq_out, src_taken, src_refused, rej_valid, eoi_valid, resend_req, rsp_valid};
    on   = rej_valid ? rej_num : (eoi_valid ? eoi_num : 24'h0);
    orsp = rsp_valid ? rsp_data : 32'h0;
    checks++;
    if (of !== flg || on !== num || orsp !== rsp) begin
      errors++;
      $display("FAIL %s: got flags=%b num=%h rsp=%h, expected flags=%b num=%h rsp=%h",
               tag, of, on, orsp, flg, num, rsp);
    end
  endtask

  task automatic check_ipi(input string tag, input logic [7:0] exp);
    checks++;
    if (rsp_ipi !== exp) begin
      errors++;
      $display("FAIL %s: rsp_ipi got %h expected %h", tag, rsp_ipi, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].is_src, VEC[i].code, VEC[i].data, VEC[i].prio, !VEC[i].is_src);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].flg, VEC[i].num, VEC[i].rsp);
    end

    // R11: request together with a poll is refused, slot unchanged
    apply(1'b1, C_POLL, 32'h00000031, 8'h01, 1'b1);
    check("R11 concurrent", 7'b1010001, 24'h0, 32'h40000023);
    apply(1'b0, C_POLL, 32'h0, 8'h00, 1'b1);
    check("R11 slot kept", 7'b1000001, 24'h0, 32'h40000023);

    // R3: request priority equal to threshold
    apply(1'b1, 3'd0, 32'h32, 8'h40, 1'b0);
    check("R3 at threshold", 7'b1010000, 24'h0, 32'h0);

    // R4: better request displaces external 0x23
    apply(1'b1, 3'd0, 32'h30, 8'h05, 1'b0);
    check("R4 displace", 7'b1101000, 24'h23, 32'h0);

    // R13: idle cycle clears every pulse
    apply(1'b0, 3'd0, 32'h0, 8'h00, 1'b0);
    check("R13 idle", 7'b1000000, 24'h0, 32'h0);

    // R12: IPI not below threshold stays unpresented; poll shows it
    apply(1'b0, C_IPI, 32'h50, 8'h00, 1'b1);
    check("R12 set ipi", 7'b1000000, 24'h0, 32'h0);
    apply(1'b0, C_POLL, 32'h0, 8'h00, 1'b1);
    check("R12 poll", 7'b1000001, 24'h0, 32'h40000030);
    check_ipi("R12 poll ipi", 8'h50);

    // R1: reset mid-run
    @(negedge clk);
    op_valid = 1'b0; src_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, C_POLL, 32'h0, 8'h00, 1'b1);
    check("R1 reset poll", 7'b0000001, 24'h0, 32'h0);
    check_ipi("R1 reset ipi", 8'hFF);
    apply(1'b0, C_ACC, 32'h0, 8'h00, 1'b1);
    check("R1 accept after reset", 7'b0000001, 24'h0, 32'h0);
    apply(1'b0, C_POLL, 32'h0, 8'h00, 1'b1);
    check("R1 threshold idle", 7'b0000001, 24'h0, 32'hFF000000);

    @(negedge clk);
    op_valid = 1'b0; src_valid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule